// File: doc/BRIEF.md
# Simplified 32-bit PCI Target

This block is a 32-bit target on a PCI-style bus where address and data share one set of wires. On the first clock of a transaction it samples the address and the bus command. It then decides whether the access belongs to it. After that it runs one or more data beats against a small internal bank of dword registers, or against a tiny configuration space. The shared AD wires are modelled as an input, an output and an output enable. A pad ring or a bus model outside the block resolves them.

The memory window is a run of `REG_COUNT` dwords. Its position is set by a base register in configuration space. Configuration cycles are claimed only while the chip-select line for configuration is high. The target answers with medium decode timing, and it never inserts wait states of its own. The initiator paces every beat with its ready line. Bursts advance one dword per completed beat. The last beat is the one that completes while the frame line is already high.

Top module: `pci_tgt_lite`

## Requirements
- R1: After reset, DEVSEL# and TRDY# are high, the AD output enable is low, and every bank dword and the base register read as zero.
- R2: The only commands claimed are 0110 (memory read), 0111 (memory write), 1010 (configuration read) and 1011 (configuration write), taken from C/BE#[3:0] in the address phase. Any other code leaves DEVSEL# high for the whole transaction.
- R3: A memory command is claimed only when AD[31:W] in the address phase equals base[31:W], where W = log2(REG_COUNT)+2 (W = 5 by default). Within the window, dword index AD[W-1:2] selects a bank entry.
- R4: A configuration command is claimed only when IDSEL is high in the address phase, and its dword index is AD[7:2]. Index 0 reads the constant DEV_ID and ignores writes. Index 4 is the base register: bits [31:W] are writable and bits [W-1:0] read zero. All other indexes read zero.
- R5: Call the address phase the rising edge that samples FRAME# low while the target is idle. DEVSEL# and TRDY# stay high through the following cycle and go low together after the second edge.
- R6: A data beat completes only on an edge where IRDY# and TRDY# are both low. On other edges no register changes and the burst address holds.
- R7: On a write beat, byte lane k (AD[8k+7:8k], where lane 0 is the least significant byte) is updated only if C/BE#[k] is low in that beat.
- R8: The dword address advances by one after each completed beat. Within the memory bank it wraps modulo REG_COUNT.
- R9: On a claimed read, the AD output enable is high exactly while TRDY# is low, and AD out then carries the dword at the current burst address.
- R10: DEVSEL# stays low until a beat completes with FRAME# high. After that edge, DEVSEL#, TRDY# and the output enable are released. The next edge is a turnaround edge on which no new address phase is taken.
- R11: After an unclaimed address phase, the target ignores the bus until it samples FRAME# and IRDY# both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 32 | Shared address/data bus as seen by the target |
| adOut | output | 32 | Read data driven toward the bus |
| adOe | output | 1 | High while the target drives AD |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frameN | input | 1 | Active-low transaction frame from the initiator |
| irdyN | input | 1 | Active-low initiator ready |
| idsel | input | 1 | Chip select for configuration cycles |
| trdyN | output | 1 | Active-low target ready |
| devselN | output | 1 | Active-low device select |

## Verification
Some rules hold on every clock, and the bound checker checks those. The output enable never rises without TRDY#. TRDY# is never low without DEVSEL#. DEVSEL# falls exactly two edges after FRAME# was sampled low. DEVSEL# holds until a final beat and is released right after one. Read data holds still through initiator wait states, and a turnaround clock always follows a release. Whether the right transactions are claimed, whether byte lanes merge correctly, and whether burst addresses wrap and land in the right dword can only be shown by the bench scenarios. These compare read-back values against a separate model of the bank and the base register, across command codes, IDSEL values, base moves and wait patterns.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_DATA,
    ST_TURN,
    ST_SKIP
  } tgtState_t;

  typedef struct packed {
    logic latchAddr;
    logic beatDone;
  } tgtStrobe_t;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

endpackage

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       claim,
  input  logic       isWrite,
  output tgtStrobe_t strobe,
  output logic       devselN,
  output logic       trdyN,
  output logic       adOe
);

  tgtState_t state;

  always_comb begin
    strobe = '0;
    strobe.latchAddr = (state == ST_IDLE) && !frameN;
    strobe.beatDone  = (state == ST_DATA) && !irdyN && !trdyN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      devselN <= 1'b1;
      trdyN   <= 1'b1;
      adOe    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!frameN) state <= claim ? ST_DECODE : ST_SKIP;
        end
        ST_DECODE: begin
          state   <= ST_DATA;
          devselN <= 1'b0;
          trdyN   <= 1'b0;
          adOe    <= !isWrite;
        end
        ST_DATA: begin
          if (!irdyN && frameN) begin
            state   <= ST_TURN;
            devselN <= 1'b1;
            trdyN   <= 1'b1;
            adOe    <= 1'b0;
          end
        end
        ST_TURN: state <= ST_IDLE;
        ST_SKIP: begin
          if (frameN && irdyN) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tgt_dpath.sv
module pci_tgt_dpath
  import pci_tgt_pkg::*;
#(
  parameter int          REG_COUNT = 8,
  parameter logic [31:0] DEV_ID    = 32'h5A17_C0DE,
  parameter int          BASE_IDX  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        idsel,
  input  tgtStrobe_t  strobe,
  output logic        claim,
  output logic        isWrite,
  output logic [31:0] adOut
);

  localparam int IDX_BITS = $clog2(REG_COUNT);
  localparam int WIN_BITS = IDX_BITS + 2;
  localparam logic [31:0] BASE_MASK = ~((32'd1 << WIN_BITS) - 32'd1);

  logic [29:0] addrQ;
  logic        cfgQ;
  logic [31:0] baseReg;
  logic [31:0] bank [REG_COUNT];
  logic [31:0] laneMask;
  logic        cmdIsMem, cmdIsCfg;
  logic        unusedLowBits;

  assign unusedLowBits = ^adIn[1:0];

  wire [IDX_BITS-1:0] memIdx = addrQ[IDX_BITS-1:0];
  wire [5:0]          cfgIdx = addrQ[5:0];

  for (genvar lane = 0; lane < 4; lane++) begin : gLane
    assign laneMask[8*lane +: 8] = {8{~cbeN[lane]}};
  end

  assign cmdIsMem = (cbeN == CMD_MEM_RD) || (cbeN == CMD_MEM_WR);
  assign cmdIsCfg = (cbeN == CMD_CFG_RD) || (cbeN == CMD_CFG_WR);
  assign claim    = (cmdIsMem && (adIn[31:WIN_BITS] == baseReg[31:WIN_BITS]))
                 || (cmdIsCfg && idsel);

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldVal,
                                             input logic [31:0] newVal,
                                             input logic [31:0] mask);
    return (oldVal & ~mask) | (newVal & mask);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      cfgQ    <= 1'b0;
      isWrite <= 1'b0;
      baseReg <= '0;
      for (int i = 0; i < REG_COUNT; i++) bank[i] <= '0;
    end else begin
      if (strobe.latchAddr) begin
        addrQ   <= adIn[31:2];
        cfgQ    <= cmdIsCfg;
        isWrite <= cbeN[0];
      end
      if (strobe.beatDone) begin
        addrQ <= addrQ + 30'd1;
        if (isWrite) begin
          if (cfgQ) begin
            if (cfgIdx == 6'(BASE_IDX))
              baseReg <= mergeLanes(baseReg, adIn, laneMask) & BASE_MASK;
          end else begin
            bank[memIdx] <= mergeLanes(bank[memIdx], adIn, laneMask);
          end
        end
      end
    end
  end

  always_comb begin
    if (cfgQ) begin
      if (cfgIdx == 6'd0)              adOut = DEV_ID;
      else if (cfgIdx == 6'(BASE_IDX)) adOut = baseReg;
      else                             adOut = '0;
    end else begin
      adOut = bank[memIdx];
    end
  end

endmodule

// File: rtl/pci_tgt_lite.sv
module pci_tgt_lite
  import pci_tgt_pkg::*;
#(
  parameter int          REG_COUNT = 8,
  parameter logic [31:0] DEV_ID    = 32'h5A17_C0DE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  output logic [31:0] adOut,
  output logic        adOe,
  input  logic [3:0]  cbeN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        idsel,
  output logic        trdyN,
  output logic        devselN
);

  tgtStrobe_t strobe;
  logic       claim;
  logic       isWrite;

  pci_tgt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .irdyN   (irdyN),
    .claim   (claim),
    .isWrite (isWrite),
    .strobe  (strobe),
    .devselN (devselN),
    .trdyN   (trdyN),
    .adOe    (adOe)
  );

  pci_tgt_dpath #(
    .REG_COUNT (REG_COUNT),
    .DEV_ID    (DEV_ID),
    .BASE_IDX  (4)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .adIn    (adIn),
    .cbeN    (cbeN),
    .idsel   (idsel),
    .strobe  (strobe),
    .claim   (claim),
    .isWrite (isWrite),
    .adOut   (adOut)
  );

endmodule

// File: rtl/pci_tgt_lite_chk.sv
module pci_tgt_lite_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] adOut,
  input logic        adOe,
  input logic        frameN,
  input logic        irdyN,
  input logic        trdyN,
  input logic        devselN
);

  assert_oe_needs_trdy_R9: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> !trdyN);

  assert_trdy_needs_devsel_R5: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  assert_medium_decode_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> !$past(frameN, 2));

  assert_release_after_final_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!devselN && !trdyN && !irdyN && frameN) |=> (devselN && trdyN && !adOe));

  assert_devsel_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!devselN && (irdyN || !frameN)) |=> !devselN);

  assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devselN) |=> devselN);

  assert_wait_holds_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && !trdyN && irdyN) |=> $stable(adOut));

endmodule

bind pci_tgt_lite pci_tgt_lite_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .adOut   (adOut),
  .adOe    (adOe),
  .frameN  (frameN),
  .irdyN   (irdyN),
  .trdyN   (trdyN),
  .devselN (devselN)
);

// File: tb/pci_tgt_lite_test.sv
module pci_tgt_lite_test;

  localparam int PERIOD = 10;
  localparam logic [31:0] ID = 32'hC0FF_EE01;
  localparam logic [3:0] MR = 4'b0110, MW = 4'b0111, CR = 4'b1010, CW = 4'b1011;
  localparam logic [31:0] WMASK = 32'hFFFF_FFE0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [31:0] adOut;
  logic        adOe;
  logic [3:0]  cbeN = 4'hF;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic        idsel = 1'b0;
  logic        trdyN;
  logic        devselN;

  int total = 0;
  int bad = 0;

  logic [31:0] mdl [8];
  logic [31:0] mdlBase;
  logic [31:0] bData [4];
  logic [3:0]  bBe [4];
  int          bWait [4];

  // {cmd, idsel, addr, data, byte enables}
  localparam logic [72:0] VEC [15] = '{
    {MW,    1'b0, 32'h0000_0004, 32'h1122_3344, 4'h0},
    {MR,    1'b0, 32'h0000_0004, 32'h0,         4'h0},
    {MW,    1'b0, 32'h0000_0008, 32'hAABB_CCDD, 4'b1010},
    {MR,    1'b0, 32'h0000_0008, 32'h0,         4'h0},
    {CR,    1'b1, 32'h0000_0000, 32'h0,         4'h0},
    {CW,    1'b1, 32'h0000_0010, 32'h4000_00FF, 4'h0},
    {CR,    1'b1, 32'h0000_0010, 32'h0,         4'h0},
    {MR,    1'b0, 32'h0000_0004, 32'h0,         4'h0},
    {MR,    1'b0, 32'h4000_00E4, 32'h0,         4'h0},
    {CR,    1'b0, 32'h0000_0000, 32'h0,         4'h0},
    {4'b0011, 1'b0, 32'h4000_00E4, 32'hFFFF_FFFF, 4'h0},
    {CW,    1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 4'h0},
    {CR,    1'b1, 32'h0000_0000, 32'h0,         4'h0},
    {CW,    1'b1, 32'h0000_0010, 32'h1234_5678, 4'b1110},
    {MR,    1'b0, 32'h4000_0064, 32'h0,         4'h0}
  };

  pci_tgt_lite #(.REG_COUNT(8), .DEV_ID(ID)) uut (
    .clk(clk), .rstN(rstN), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .cbeN(cbeN), .frameN(frameN), .irdyN(irdyN), .idsel(idsel),
    .trdyN(trdyN), .devselN(devselN)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{~be[k]}};
    return m;
  endfunction

  function automatic bit mClaim(input logic [3:0] cmd, input logic sel, input logic [31:0] addr);
    if (cmd == MR || cmd == MW) return (addr & WMASK) == (mdlBase & WMASK);
    if (cmd == CR || cmd == CW) return sel;
    return 1'b0;
  endfunction

  function automatic logic [31:0] mRead(input logic [3:0] cmd, input logic [31:0] addr);
    if (cmd[3]) begin
      if (addr[7:2] == 6'd0) return ID;
      if (addr[7:2] == 6'd4) return mdlBase;
      return 32'h0;
    end
    return mdl[addr[4:2]];
  endfunction

  task automatic mWrite(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m = lanes(be);
    if (cmd[3]) begin
      if (addr[7:2] == 6'd4) mdlBase = ((mdlBase & ~m) | (d & m)) & WMASK;
    end else begin
      mdl[addr[4:2]] = (mdl[addr[4:2]] & ~m) | (d & m);
    end
  endtask

  task automatic mReset();
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    mdlBase = 32'h0;
  endtask

  task automatic xfer(input logic [3:0] cmd, input logic sel, input logic [31:0] addr,
                      input int n, input string tag);
    bit claim = mClaim(cmd, sel, addr);
    bit isWr = cmd[0];
    int beat = 0;
    int w = 0;
    int cyc = 0;
    @(negedge clk);
    frameN = 1'b0; adIn = addr; cbeN = cmd; idsel = sel; irdyN = 1'b1;
    while (beat < n) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk(devselN === 1'b1 && trdyN === 1'b1 && adOe === 1'b0, "R5 no fast decode",
            {29'h0, devselN, trdyN, adOe}, 32'h6);
      end
      if (claim && cyc == 2) begin
        chk(devselN === 1'b0 && trdyN === 1'b0, "R5 medium decode",
            {30'h0, devselN, trdyN}, 32'h0);
      end
      if (!claim) begin
        chk(devselN === 1'b1, {tag, " unclaimed"}, {31'h0, devselN}, 32'h1);
      end
      if (w < bWait[beat]) begin
        irdyN = 1'b1; adIn = 32'hBAD0_BAD0; cbeN = 4'h0; w++;
      end else begin
        irdyN = 1'b0;
        adIn = isWr ? bData[beat] : 32'h0;
        cbeN = bBe[beat];
        frameN = (beat == n - 1);
        if (claim && trdyN === 1'b0) begin
          if (!isWr) begin
            chk(adOe === 1'b1 && adOut === mRead(cmd, addr + 32'(4 * beat)), tag,
                adOut, mRead(cmd, addr + 32'(4 * beat)));
          end else begin
            mWrite(cmd, addr + 32'(4 * beat), bData[beat], bBe[beat]);
          end
          beat++;
          w = 0;
        end
      end
      if (!claim && cyc >= 4) break;
    end
    @(negedge clk);
    frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF; idsel = 1'b0;
    chk(devselN === 1'b1 && trdyN === 1'b1 && adOe === 1'b0, claim ? "R10 release" : "R11 idle",
        {29'h0, devselN, trdyN, adOe}, 32'h6);
  endtask

  initial begin
    #(PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mReset();
    repeat (3) @(negedge clk);
    chk(devselN === 1'b1 && trdyN === 1'b1 && adOe === 1'b0, "R1 reset outputs",
        {29'h0, devselN, trdyN, adOe}, 32'h6);
    rstN = 1'b1;
    @(negedge clk);

    // R1: bank and base start at zero
    bData[0] = 0; bBe[0] = 4'h0; bWait[0] = 0;
    xfer(MR, 1'b0, 32'h0000_0000, 1, "R1 bank zero");
    xfer(CR, 1'b1, 32'h0000_0010, 1, "R1 base zero");

    // Table walk: single-beat transactions
    for (int i = 0; i < 15; i++) begin
      string tag;
      logic [3:0] c = VEC[i][72:69];
      if (i == 2 || i == 3 || i == 13) tag = "R7";
      else if (c == MR || c == MW) tag = "R3";
      else if (c == CR || c == CW) tag = "R4";
      else tag = "R2";
      bData[0] = VEC[i][35:4];
      bBe[0]   = VEC[i][3:0];
      bWait[0] = 0;
      xfer(c, VEC[i][68], VEC[i][67:36], 1, tag);
    end

    // R6/R7/R8: burst write wrapping the window, with initiator waits
    bData[0] = 32'h6666_0006; bBe[0] = 4'h0;    bWait[0] = 0;
    bData[1] = 32'h7777_0007; bBe[1] = 4'h0;    bWait[1] = 2;
    bData[2] = 32'h8888_0000; bBe[2] = 4'b1100; bWait[2] = 0;
    bData[3] = 32'h9999_0001; bBe[3] = 4'h0;    bWait[3] = 1;
    xfer(MW, 1'b0, 32'h4000_0078, 4, "R8 burst write");

    // R6/R8: burst read back with waits
    bWait[0] = 1; bWait[1] = 0; bWait[2] = 3; bWait[3] = 0;
    bBe[0] = 4'h0; bBe[1] = 4'h0; bBe[2] = 4'h0; bBe[3] = 4'h0;
    xfer(MR, 1'b0, 32'h4000_0078, 4, "R6 R8 burst read");

    // R7: dword 2 kept its untouched lanes
    bWait[0] = 0;
    xfer(MR, 1'b0, 32'h4000_0068, 1, "R7 lanes kept");

    // R1: reset mid-run clears base and bank
    @(negedge clk);
    rstN = 1'b0;
    mReset();
    @(negedge clk);
    chk(devselN === 1'b1 && trdyN === 1'b1 && adOe === 1'b0, "R1 reset again",
        {29'h0, devselN, trdyN, adOe}, 32'h6);
    rstN = 1'b1;
    xfer(MR, 1'b0, 32'h0000_0004, 1, "R1 bank cleared");
    xfer(MR, 1'b0, 32'h4000_0064, 1, "R3 old window gone");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule